// File: doc/BRIEF.md
# Sampling Clock Controller Register Block

This block holds the software-visible settings of a sampling clock controller that sits next to an SD host interface. A driver programs it over a plain register bus (address, write enable, write data, read data). It keeps the tap enable and the number of taps, the chosen tap, the data-to-flip-flop position, the choice between the tuned and the default sampling clock, and the automatic re-tune enable. Each setting is driven straight out on a port for the phase-generation logic, which is not part of this block.

A one-cycle pulse from the sampling logic records a re-tune error, but only while automatic re-tuning is enabled. Software clears the flag by writing zero to the status register. The block raises a single combined error output when the flag and the re-tune enable are both set. Register spacing on the bus is set by a shift parameter, so the same map serves 16-, 32- or 64-bit register strides.

Top module: `sclk_ctrl_regs`

## Requirements
- R1: After reset, the tap-count field reads 8 and every other field, port and flag is zero.
- R2: Register n (n = 0..5) answers at byte address (2*n) << BUS_SHIFT: 0 tap control, 1 tap select, 2 flip-flop position, 3 clock select, 4 re-tune control, 5 re-tune status. The default BUS_SHIFT is 2, so the addresses are 0x00, 0x08, 0x10, 0x18, 0x20 and 0x28.
- R3: In the tap control register, bit 0 is the tap enable and bits 23:16 are the tap count. Both can be read back and drive tap_en and tap_count. All other bits read zero.
- R4: The tap select and flip-flop position registers each hold an 8-bit value in bits 7:0 that can be read back and appears on tap_sel and ff_pos. Higher bits read zero.
- R5: Bit 0 of the clock select register drives clk_sel. A 1 selects the tuned clock and a 0 selects the default clock.
- R6: Bit 0 of the re-tune control register is the auto re-tune enable and drives retune_en.
- R7: The error flag reads at bit 2 of the re-tune status register. A sample_err_pulse sets it only if the enable register already held 1 in that cycle. A pulse while the enable is 0 is ignored.
- R8: Writing all-zero data to the status register clears the flag. Writing non-zero data there leaves it unchanged. A set pulse and a clearing write in the same cycle leave the flag set.
- R9: retune_err is high exactly when the flag and the enable are both 1. Dropping the enable hides the error without clearing the flag.
- R10: Any address outside the map, including one that is not aligned to the stride, reads zero, and a write to it changes no state.
- R11: A write takes effect on the rising clock edge where bus_we is high. Read data is combinational from the current address and the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sample_err_pulse | input | 1 | One-cycle sampling error report |
| tap_en | output | 1 | Tap enable |
| tap_count | output | 8 | Number of taps |
| tap_sel | output | 8 | Chosen tap |
| ff_pos | output | 8 | Data-to-flip-flop position |
| clk_sel | output | 1 | 1 selects the tuned clock, 0 the default |
| retune_en | output | 1 | Auto re-tune enable |
| retune_err | output | 1 | Combined re-tune error indication |

## Verification
The assertions assume that bus_we and sample_err_pulse are both known, never X, in every cycle after reset. They also assume that the inputs change only between clock edges, so the enable value seen by a pulse is the one already registered. The stimulus follows these rules: every input is driven on the falling edge, and every write and pulse lasts exactly one cycle. Random traffic mixes mapped, unaligned and arbitrary addresses with zero and non-zero status writes and with pulses that fall both inside and outside enabled windows. Directed cases add a pulse and a clearing write in the same cycle, and an enable that drops and comes back while the flag is set.

// File: rtl/sclk_regs_pkg.sv
package sclk_regs_pkg;

    localparam int DATA_W     = 32;
    localparam int TAP_W      = 8;
    localparam int NUM_REGS   = 6;
    localparam int TAPCNT_LSB = 16;
    localparam int ERR_BIT    = 2;

    // Register indices; the index order fixes the address map.
    localparam int IDX_TAPCTL = 0;
    localparam int IDX_TAPSEL = 1;
    localparam int IDX_FFPOS  = 2;
    localparam int IDX_CLKSEL = 3;
    localparam int IDX_RTCTL  = 4;
    localparam int IDX_RTSTAT = 5;

    typedef struct packed {
        logic             tap_en;
        logic [TAP_W-1:0] tap_cnt;
        logic [TAP_W-1:0] tap_sel;
        logic [TAP_W-1:0] ff_pos;
        logic             clk_sel;
        logic             rt_en;
    } ctl_regs_t;

    // Unshifted offset of a register: consecutive even offsets.
    function automatic int unsigned reg_offset(input int unsigned idx);
        return 2 * idx;
    endfunction

endpackage

// File: rtl/sclk_addr_dec.sv
module sclk_addr_dec
    import sclk_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUS_SHIFT = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
        localparam logic [ADDR_W-1:0] MATCH_ADDR =
            ADDR_W'(reg_offset(g) << BUS_SHIFT);
        assign sel[g] = (addr == MATCH_ADDR);
    end

endmodule

// File: rtl/sclk_rd_mux.sv
module sclk_rd_mux #(
    parameter int NREG = 6,
    parameter int DW   = 32
) (
    input  logic [NREG-1:0]    sel,
    input  logic [NREG*DW-1:0] words,
    output logic [DW-1:0]      rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                rdata = rdata | words[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/sclk_err_flag.sv
module sclk_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic err_pulse,
    input  logic rt_en,
    input  logic clr_wr,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (err_pulse && rt_en) begin
            flag_d = 1'b1;
        end else if (clr_wr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    assert_set_when_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && rt_en) |=> flag);

    assert_pulse_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !rt_en && !flag) |=> !flag);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && rt_en && clr_wr) |=> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(err_pulse && rt_en)) |=> !flag);

endmodule

// File: rtl/sclk_ctrl_regs.sv
module sclk_ctrl_regs
    import sclk_regs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BUS_SHIFT  = 2,
    parameter int TAPCNT_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sample_err_pulse,
    output logic              tap_en,
    output logic [TAP_W-1:0]  tap_count,
    output logic [TAP_W-1:0]  tap_sel,
    output logic [TAP_W-1:0]  ff_pos,
    output logic              clk_sel,
    output logic              retune_en,
    output logic              retune_err
);

    localparam ctl_regs_t RST_VAL = '{
        tap_en:  1'b0,
        tap_cnt: TAP_W'(TAPCNT_RST),
        tap_sel: '0,
        ff_pos:  '0,
        clk_sel: 1'b0,
        rt_en:   1'b0
    };

    logic [NUM_REGS-1:0]        reg_sel;
    logic [NUM_REGS*DATA_W-1:0] rd_words;
    ctl_regs_t                  regs_d, regs_q;
    logic                       err_flag;
    logic                       clr_wr;

    sclk_addr_dec #(
        .ADDR_W    (ADDR_W),
        .BUS_SHIFT (BUS_SHIFT)
    ) u_dec (
        .addr (bus_addr),
        .sel  (reg_sel)
    );

    // Next-state computation for all control fields.
    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (reg_sel[IDX_TAPCTL]) begin
                regs_d.tap_en  = bus_wdata[0];
                regs_d.tap_cnt = bus_wdata[TAPCNT_LSB +: TAP_W];
            end
            if (reg_sel[IDX_TAPSEL]) regs_d.tap_sel = bus_wdata[TAP_W-1:0];
            if (reg_sel[IDX_FFPOS])  regs_d.ff_pos  = bus_wdata[TAP_W-1:0];
            if (reg_sel[IDX_CLKSEL]) regs_d.clk_sel = bus_wdata[0];
            if (reg_sel[IDX_RTCTL])  regs_d.rt_en   = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RST_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign clr_wr = bus_we && reg_sel[IDX_RTSTAT] && (bus_wdata == '0);

    sclk_err_flag u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (sample_err_pulse),
        .rt_en     (regs_q.rt_en),
        .clr_wr    (clr_wr),
        .flag      (err_flag)
    );

    // Read-back words laid out by register index.
    always_comb begin
        rd_words = '0;
        rd_words[IDX_TAPCTL*DATA_W + 0]                        = regs_q.tap_en;
        rd_words[IDX_TAPCTL*DATA_W + TAPCNT_LSB +: TAP_W]      = regs_q.tap_cnt;
        rd_words[IDX_TAPSEL*DATA_W +: TAP_W]                   = regs_q.tap_sel;
        rd_words[IDX_FFPOS*DATA_W +: TAP_W]                    = regs_q.ff_pos;
        rd_words[IDX_CLKSEL*DATA_W + 0]                        = regs_q.clk_sel;
        rd_words[IDX_RTCTL*DATA_W + 0]                         = regs_q.rt_en;
        rd_words[IDX_RTSTAT*DATA_W + ERR_BIT]                  = err_flag;
    end

    sclk_rd_mux #(
        .NREG (NUM_REGS),
        .DW   (DATA_W)
    ) u_rd (
        .sel   (reg_sel),
        .words (rd_words),
        .rdata (bus_rdata)
    );

    assign tap_en     = regs_q.tap_en;
    assign tap_count  = regs_q.tap_cnt;
    assign tap_sel    = regs_q.tap_sel;
    assign ff_pos     = regs_q.ff_pos;
    assign clk_sel    = regs_q.clk_sel;
    assign retune_en  = regs_q.rt_en;
    assign retune_err = regs_q.rt_en & err_flag;

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tap_count == TAP_W'(TAPCNT_RST) && !tap_en && tap_sel == '0
                          && ff_pos == '0 && !clk_sel && !retune_en && !retune_err));

    assert_tapcnt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel[IDX_TAPCTL]) |=>
            (tap_count == $past(bus_wdata[TAPCNT_LSB +: TAP_W]) && tap_en == $past(bus_wdata[0])));

    assert_err_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retune_en) |-> !retune_err);

    assert_unmapped_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel == '0) |=> $stable(regs_q));

endmodule

// File: tb/sim_sclk_ctrl_regs.sv
module sim_sclk_ctrl_regs;

    localparam int SH     = 2;
    localparam int AW     = 8;
    localparam int NRAND  = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sample_err_pulse = 1'b0;
    logic          tap_en;
    logic [7:0]    tap_count, tap_sel, ff_pos;
    logic          clk_sel, retune_en, retune_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Bench model of the register state
    logic       m_ten, m_csel, m_ren, m_err;
    logic [7:0] m_tcnt, m_tsel, m_fpos;

    always #10 clk = ~clk;

    sclk_ctrl_regs #(.ADDR_W(AW), .BUS_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sample_err_pulse(sample_err_pulse), .tap_en(tap_en),
        .tap_count(tap_count), .tap_sel(tap_sel), .ff_pos(ff_pos),
        .clk_sel(clk_sel), .retune_en(retune_en), .retune_err(retune_err)
    );

    function automatic logic [AW-1:0] addr_of(input int n);
        return AW'((2 * n) << SH);
    endfunction

    function automatic int idx_of(input logic [AW-1:0] a);
        for (int n = 0; n < 6; n++) if (a == addr_of(n)) return n;
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (idx_of(a))
            0: return {8'h00, m_tcnt, 15'h0, m_ten};
            1: return {24'h0, m_tsel};
            2: return {24'h0, m_fpos};
            3: return {31'h0, m_csel};
            4: return {31'h0, m_ren};
            5: return {29'h0, m_err, 2'b00};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ports();
        chk("R3 tap_en", {31'h0, tap_en}, {31'h0, m_ten});
        chk("R3 tap_count", {24'h0, tap_count}, {24'h0, m_tcnt});
        chk("R4 tap_sel", {24'h0, tap_sel}, {24'h0, m_tsel});
        chk("R4 ff_pos", {24'h0, ff_pos}, {24'h0, m_fpos});
        chk("R5 clk_sel", {31'h0, clk_sel}, {31'h0, m_csel});
        chk("R6 retune_en", {31'h0, retune_en}, {31'h0, m_ren});
        chk("R9 retune_err", {31'h0, retune_err}, {31'h0, m_ren & m_err});
    endtask

    // One clock with optional write and pulse; model updated per R7/R8/R11.
    task automatic step(input logic we, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic p);
        int n;
        logic n_err;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; sample_err_pulse = p;
        n = idx_of(a);
        n_err = (p && m_ren) ? 1'b1 : ((we && n == 5 && d == 32'h0) ? 1'b0 : m_err);
        @(posedge clk);
        #1;
        m_err = n_err;
        if (we) begin
            case (n)
                0: begin m_ten = d[0]; m_tcnt = d[23:16]; end
                1: m_tsel = d[7:0];
                2: m_fpos = d[7:0];
                3: m_csel = d[0];
                4: m_ren  = d[0];
                default: ;
            endcase
        end
        chk_ports();
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        bus_we = 1'b0; sample_err_pulse = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R11 watchdog actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17C0DE));
        m_ten = 0; m_csel = 0; m_ren = 0; m_err = 0;
        m_tcnt = 8'd8; m_tsel = 0; m_fpos = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 tap_count reset", {24'h0, tap_count}, 32'd8);
        chk_ports();
        for (int n = 0; n < 6; n++) rd_chk("R1 reset readback", addr_of(n));

        // R3 / R2: only defined bits stick
        step(1'b1, addr_of(0), 32'hFFFF_FFFF, 1'b0);
        rd_chk("R3 tapctl mask", addr_of(0));
        chk("R3 tapctl value", bus_rdata, 32'h00FF_0001);
        step(1'b1, addr_of(1), 32'hABCD_1234, 1'b0);
        rd_chk("R4 tapsel mask", addr_of(1));
        chk("R4 tapsel value", bus_rdata, 32'h0000_0034);

        // R10: unaligned and out-of-map addresses
        step(1'b1, addr_of(1) + AW'(1), 32'h0000_0077, 1'b0);
        rd_chk("R10 tapsel untouched", addr_of(1));
        rd_chk("R10 unaligned read", addr_of(2) + AW'(2));
        chk("R10 unaligned value", bus_rdata, 32'h0);
        step(1'b1, 8'hF0, 32'hFFFF_FFFF, 1'b1);

        // R7: pulse while disabled ignored
        step(1'b0, '0, '0, 1'b1);
        rd_chk("R7 ignored pulse", addr_of(5));
        chk("R7 flag clear", bus_rdata, 32'h0);
        // enable, pulse sets
        step(1'b1, addr_of(4), 32'h1, 1'b0);
        step(1'b0, '0, '0, 1'b1);
        chk("R9 err raised", {31'h0, retune_err}, 32'h1);
        rd_chk("R7 flag set", addr_of(5));
        chk("R7 flag value", bus_rdata, 32'h4);
        // R9: disable hides but keeps
        step(1'b1, addr_of(4), 32'h0, 1'b0);
        chk("R9 hidden", {31'h0, retune_err}, 32'h0);
        rd_chk("R9 flag kept", addr_of(5));
        step(1'b1, addr_of(4), 32'h1, 1'b0);
        chk("R9 reappears", {31'h0, retune_err}, 32'h1);
        // R8: non-zero write keeps, set beats clear, zero write clears
        step(1'b1, addr_of(5), 32'h4, 1'b0);
        rd_chk("R8 nonzero write keeps", addr_of(5));
        step(1'b1, addr_of(5), 32'h0, 1'b1);
        rd_chk("R8 set wins", addr_of(5));
        chk("R8 set wins value", bus_rdata, 32'h4);
        step(1'b1, addr_of(5), 32'h0, 1'b0);
        rd_chk("R8 cleared", addr_of(5));
        chk("R8 cleared value", bus_rdata, 32'h0);

        // Random traffic (R2..R11)
        for (int k = 0; k < NRAND; k++) begin
            int sel;
            logic [AW-1:0] a;
            logic [31:0] d;
            sel = int'($urandom % 9);
            a = (sel < 6) ? addr_of(sel) : AW'($urandom);
            d = $urandom;
            if (sel == 5 && ($urandom % 2) == 0) d = 32'h0;
            if (sel == 4) d = {31'h0, d[0]};
            step(($urandom % 3) != 0, a, d, ($urandom % 5) == 0);
            if ((k % 4) == 0) begin
                logic [AW-1:0] ra;
                ra = ((k % 8) == 0) ? addr_of(int'($urandom % 6)) : AW'($urandom);
                rd_chk("R2 R11 random readback", ra);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule